// File: doc/BRIEF.md
# Dual-Core Doorbell and Lock Unit

This block sits between two processor cores as a shared peripheral. It lets each core ring the other with up to 32 independent request bits and gives both cores one hardware lock for guarding a shared resource. Each core owns one request word. The other core sets bits in it, and the owner clears them once it has serviced them. While the owner's word holds any set bit, the owner's interrupt line stays high.

The block has two access lanes. A lane carries a select, a write strobe, a 2-bit word address, write data and a one-bit core-ID sideband that names the issuing core. Addresses are relative to the caller: the same offset means "ring my peer" or "clear my own bits" depending on the core ID. Read data is registered and appears on the lane one clock after the request. The lock follows read-to-acquire semantics, so a single read both tests and takes it.

Top module: `xcore_doorbell`

## Requirements
- R1: After synchronous reset both request words are zero, both interrupt lines are low, and the lock is free, so the first lock read returns 1.
- R2: A write to offset 0 (ring peer) from core c ORs the write data into the request word of core 1-c. Zero data bits leave the word unchanged. Bit 31 and bit 0 behave like every other bit.
- R3: A write to offset 1 (clear own) from core c clears the bits of core c's word where the data is 1. It leaves all other bits and the other core's word untouched.
- R4: A read of offset 2 (own status) from core c returns core c's request word on that lane's read data one cycle after the request.
- R5: Interrupt line c is high exactly while core c's request word is non-zero, starting in the cycle after the write that changes the word.
- R6: When a set and a clear hit the same bit of a word in one cycle, the set wins. When both cores ring each other in one cycle, both words update.
- R7: A read of offset 3 (lock) returns 1 in bit 0, with every other bit 0, and takes the lock if it was free. It returns 0 and changes nothing if the lock was held.
- R8: A write of offset 3 with data bit 0 at 1 frees the lock, whichever core writes it. A write with bit 0 at 0 has no effect.
- R9: When both cores read the lock in the same cycle while it is free, the core with ID 0 receives 1 and the other receives 0, whichever lane each uses.
- R10: A write to offset 2 changes nothing. Reads of offsets 0 and 1 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 2 | Per-lane access select |
| bus_wr | input | 2 | Per-lane write strobe (0 = read) |
| bus_cid | input | 2 | Per-lane issuing core ID |
| bus_addr | input | 2x2 | Per-lane word offset |
| bus_wdata | input | 2x32 | Per-lane write data |
| bus_rdata | output | 2x32 | Per-lane read data, one cycle after the request |
| irq | output | 2 | Per-core interrupt, high while that core's word is non-zero |

## Verification
The assertions assume that when both lanes are active in one cycle they carry different core IDs, since each lane stands for one core's port. They also assume the reset is held for at least one clock edge before traffic starts. The bench drives both lanes together only in its dual-access scenarios, and in every such cycle it gives them distinct core IDs. It swaps the lane-to-core mapping between runs so that the lock priority follows the ID and not the lane index.

// File: rtl/dbell_pkg.sv
package dbell_pkg;

    localparam int NCORE  = 2;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        OFS_RING_PEER = 2'd0,
        OFS_CLR_OWN   = 2'd1,
        OFS_STAT_OWN  = 2'd2,
        OFS_LOCK      = 2'd3
    } dbell_ofs_e;

    typedef struct packed {
        logic ring_peer;
        logic clr_own;
        logic stat_rd;
        logic lock_rd;
        logic lock_rel;
    } lane_op_t;

    function automatic logic peer_of(input logic cid);
        return ~cid;
    endfunction

endpackage

// File: rtl/dbell_decode.sv
module dbell_decode
    import dbell_pkg::*;
(
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wbit0,
    output lane_op_t          op
);

    always_comb begin
        op = '0;
        if (sel) begin
            case (addr)
                OFS_RING_PEER: op.ring_peer = wr;
                OFS_CLR_OWN:   op.clr_own   = wr;
                OFS_STAT_OWN:  op.stat_rd   = !wr;
                OFS_LOCK: begin
                    op.lock_rd  = !wr;
                    op.lock_rel = wr & wbit0;
                end
                default: op = '0;
            endcase
        end
    end

endmodule

// File: rtl/dbell_word.sv
module dbell_word #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] set_mask,
    input  logic [DW-1:0] clr_mask,
    output logic [DW-1:0] word,
    output logic          irq
);

    logic [DW-1:0] word_q;

    always_ff @(posedge clk) begin
        if (rst) word_q <= '0;
        else     word_q <= (word_q & ~clr_mask) | set_mask;
    end

    assign word = word_q;
    assign irq  = |word_q;

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (word == '0 && !irq));

    assert_set_sticks_R2: assert property (@(posedge clk) disable iff (rst)
        (|set_mask) |=> ((word & $past(set_mask)) == $past(set_mask)));

    assert_clear_drops_R3: assert property (@(posedge clk) disable iff (rst)
        (|(clr_mask & ~set_mask)) |=> ((word & $past(clr_mask & ~set_mask)) == '0));

    assert_set_raises_irq_R5: assert property (@(posedge clk) disable iff (rst)
        (|set_mask) |=> irq);

endmodule

// File: rtl/dbell_mutex.sv
module dbell_mutex
    import dbell_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NCORE-1:0] rd_req,
    input  logic [NCORE-1:0] rd_cid,
    input  logic [NCORE-1:0] rel_req,
    output logic [NCORE-1:0] grant,
    output logic             locked
);

    logic locked_q;

    for (genvar l = 0; l < NCORE; l++) begin : g_arb
        localparam int OTH = NCORE - 1 - l;
        logic beaten;
        assign beaten = rd_req[OTH] &&
                        ((rd_cid[OTH] < rd_cid[l]) ||
                         ((rd_cid[OTH] == rd_cid[l]) && (OTH < l)));
        assign grant[l] = !locked_q && rd_req[l] && !beaten;
    end

    always_ff @(posedge clk) begin
        if (rst)             locked_q <= 1'b0;
        else if (|grant)     locked_q <= 1'b1;
        else if (|rel_req)   locked_q <= 1'b0;
    end

    assign locked = locked_q;

    assert_single_owner_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    assert_core0_first_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_req == 2'b11 && !locked && rd_cid[0] != rd_cid[1])
            |-> (grant[0] == (rd_cid[0] == 1'b0)));

    assert_release_frees_R8: assert property (@(posedge clk) disable iff (rst)
        ((|rel_req) && !(|grant)) |=> !locked);

endmodule

// File: rtl/xcore_doorbell.sv
module xcore_doorbell
    import dbell_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NCORE-1:0]             bus_sel,
    input  logic [NCORE-1:0]             bus_wr,
    input  logic [NCORE-1:0]             bus_cid,
    input  logic [NCORE-1:0][ADDR_W-1:0] bus_addr,
    input  logic [NCORE-1:0][DW-1:0]     bus_wdata,
    output logic [NCORE-1:0][DW-1:0]     bus_rdata,
    output logic [NCORE-1:0]             irq
);

    lane_op_t [NCORE-1:0]         op;
    logic [NCORE-1:0][DW-1:0]     set_acc, clr_acc, word;
    logic [NCORE-1:0]             lock_rd, lock_rel, grant;
    logic                         locked;
    logic [NCORE-1:0][DW-1:0]     rdata_q;

    for (genvar l = 0; l < NCORE; l++) begin : g_lane
        dbell_decode u_dec (
            .sel   (bus_sel[l]),
            .wr    (bus_wr[l]),
            .addr  (bus_addr[l]),
            .wbit0 (bus_wdata[l][0]),
            .op    (op[l])
        );
        assign lock_rd[l]  = op[l].lock_rd;
        assign lock_rel[l] = op[l].lock_rel;
    end

    always_comb begin
        set_acc = '0;
        clr_acc = '0;
        for (int l = 0; l < NCORE; l++) begin
            if (op[l].ring_peer)
                set_acc[peer_of(bus_cid[l])] = set_acc[peer_of(bus_cid[l])] | bus_wdata[l];
            if (op[l].clr_own)
                clr_acc[bus_cid[l]] = clr_acc[bus_cid[l]] | bus_wdata[l];
        end
    end

    for (genvar c = 0; c < NCORE; c++) begin : g_core
        dbell_word #(.DW(DW)) u_word (
            .clk      (clk),
            .rst      (rst),
            .set_mask (set_acc[c]),
            .clr_mask (clr_acc[c]),
            .word     (word[c]),
            .irq      (irq[c])
        );
    end

    dbell_mutex u_lock (
        .clk     (clk),
        .rst     (rst),
        .rd_req  (lock_rd),
        .rd_cid  (bus_cid),
        .rel_req (lock_rel),
        .grant   (grant),
        .locked  (locked)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else begin
            for (int l = 0; l < NCORE; l++) begin
                if (op[l].stat_rd)      rdata_q[l] <= word[bus_cid[l]];
                else if (op[l].lock_rd) rdata_q[l] <= {{(DW-1){1'b0}}, grant[l]};
                else                    rdata_q[l] <= '0;
            end
        end
    end

    assign bus_rdata = rdata_q;

    assert_lock_busy_reads_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (locked && op[0].lock_rd) |=> (bus_rdata[0] == '0));

endmodule

// File: tb/sim_xcore_doorbell.sv
module sim_xcore_doorbell;
    import dbell_pkg::*;

    localparam int DW = 32;

    logic                         clk = 1'b0;
    logic                         rst;
    logic [NCORE-1:0]             bus_sel, bus_wr, bus_cid;
    logic [NCORE-1:0][ADDR_W-1:0] bus_addr;
    logic [NCORE-1:0][DW-1:0]     bus_wdata;
    logic [NCORE-1:0][DW-1:0]     bus_rdata;
    logic [NCORE-1:0]             irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    xcore_doorbell #(.DW(DW)) u0 (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_cid(bus_cid),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic idle();
        bus_sel = '0; bus_wr = '0; bus_cid = 2'b10; bus_addr = '0; bus_wdata = '0;
    endtask

    // One access on lane 0; returns that lane's read data one cycle later.
    task automatic acc(input logic cid, input logic wr, input logic [1:0] ofs,
                       input logic [DW-1:0] d, output logic [DW-1:0] rd);
        bus_sel[0] = 1'b1; bus_wr[0] = wr; bus_cid[0] = cid;
        bus_addr[0] = ofs; bus_wdata[0] = d;
        @(negedge clk);
        rd = bus_rdata[0];
        idle();
    endtask

    task automatic dual(input logic c0, input logic w0, input logic [1:0] a0, input logic [DW-1:0] d0,
                        input logic c1, input logic w1, input logic [1:0] a1, input logic [DW-1:0] d1,
                        output logic [DW-1:0] r0, output logic [DW-1:0] r1);
        bus_sel = 2'b11; bus_wr = {w1, w0}; bus_cid = {c1, c0};
        bus_addr[0] = a0; bus_addr[1] = a1; bus_wdata[0] = d0; bus_wdata[1] = d1;
        @(negedge clk);
        r0 = bus_rdata[0]; r1 = bus_rdata[1];
        idle();
    endtask

    task automatic t_reset();
        logic [DW-1:0] r;
        check("R1 irq after reset", {30'd0, irq}, 32'd0);
        acc(1'b0, 1'b0, 2'd2, '0, r); check("R1 core0 word after reset", r, 32'd0);
        acc(1'b1, 1'b0, 2'd2, '0, r); check("R1 core1 word after reset", r, 32'd0);
    endtask

    task automatic t_lock();
        logic [DW-1:0] r;
        acc(1'b0, 1'b0, 2'd3, '0, r); check("R1 R7 first lock read is free", r, 32'd1);
        acc(1'b1, 1'b0, 2'd3, '0, r); check("R7 held lock reads 0", r, 32'd0);
        acc(1'b1, 1'b1, 2'd3, 32'hFFFF_FFFE, r);
        acc(1'b0, 1'b0, 2'd3, '0, r); check("R8 write of bit0=0 keeps lock", r, 32'd0);
        acc(1'b1, 1'b1, 2'd3, 32'd1, r);
        acc(1'b1, 1'b0, 2'd3, '0, r); check("R8 release by other core frees", r, 32'd1);
        acc(1'b1, 1'b1, 2'd3, 32'd1, r);
    endtask

    task automatic t_ring();
        logic [DW-1:0] r;
        acc(1'b0, 1'b1, 2'd0, 32'h0000_00A5, r);
        check("R5 irq after ring of core1", {30'd0, irq}, 32'd2);
        acc(1'b1, 1'b0, 2'd2, '0, r); check("R2 R4 core1 sees ring", r, 32'h0000_00A5);
        acc(1'b0, 1'b0, 2'd2, '0, r); check("R2 core0 word untouched", r, 32'd0);
        acc(1'b0, 1'b1, 2'd0, 32'h8000_0F01, r);
        acc(1'b1, 1'b0, 2'd2, '0, r); check("R2 OR into word incl bit31", r, 32'h8000_0FA5);
    endtask

    task automatic t_clear();
        logic [DW-1:0] r;
        acc(1'b1, 1'b1, 2'd1, 32'h8000_0005, r);
        acc(1'b1, 1'b0, 2'd2, '0, r); check("R3 clear only 1 bits", r, 32'h0000_0FA0);
        acc(1'b0, 1'b1, 2'd1, 32'hFFFF_FFFF, r);
        acc(1'b1, 1'b0, 2'd2, '0, r); check("R3 core0 clear spares core1 word", r, 32'h0000_0FA0);
        check("R5 irq1 still high", {30'd0, irq}, 32'd2);
        acc(1'b1, 1'b1, 2'd1, 32'hFFFF_FFFF, r);
        check("R5 irq drops when word empty", {30'd0, irq}, 32'd0);
    endtask

    task automatic t_race();
        logic [DW-1:0] r0, r1, r;
        acc(1'b0, 1'b1, 2'd0, 32'h0000_0001, r);
        dual(1'b0, 1'b1, 2'd0, 32'h0000_0003, 1'b1, 1'b1, 2'd1, 32'h0000_0001, r0, r1);
        acc(1'b1, 1'b0, 2'd2, '0, r); check("R6 set beats clear on same bit", r, 32'h0000_0003);
        dual(1'b1, 1'b1, 2'd0, 32'h0000_0010, 1'b0, 1'b1, 2'd0, 32'h0000_0020, r0, r1);
        acc(1'b0, 1'b0, 2'd2, '0, r); check("R6 mutual ring core0", r, 32'h0000_0010);
        acc(1'b1, 1'b0, 2'd2, '0, r); check("R6 mutual ring core1", r, 32'h0000_0023);
        check("R5 both irq high", {30'd0, irq}, 32'd3);
        dual(1'b0, 1'b1, 2'd1, 32'hFFFF_FFFF, 1'b1, 1'b1, 2'd1, 32'hFFFF_FFFF, r0, r1);
        check("R3 both cleared", {30'd0, irq}, 32'd0);
    endtask

    task automatic t_ignore();
        logic [DW-1:0] r;
        acc(1'b0, 1'b1, 2'd0, 32'h0000_1234, r);
        acc(1'b1, 1'b1, 2'd2, 32'hFFFF_FFFF, r);
        acc(1'b1, 1'b0, 2'd2, '0, r); check("R10 write to status ignored", r, 32'h0000_1234);
        acc(1'b1, 1'b0, 2'd0, '0, r); check("R10 read offset0 is zero", r, 32'd0);
        acc(1'b1, 1'b0, 2'd1, '0, r); check("R10 read offset1 is zero", r, 32'd0);
        acc(1'b1, 1'b1, 2'd1, 32'hFFFF_FFFF, r);
    endtask

    task automatic t_prio();
        logic [DW-1:0] r0, r1, r;
        dual(1'b1, 1'b0, 2'd3, '0, 1'b0, 1'b0, 2'd3, '0, r0, r1);
        check("R9 core0 on lane1 wins", r1, 32'd1);
        check("R9 core1 on lane0 loses", r0, 32'd0);
        acc(1'b0, 1'b1, 2'd3, 32'd1, r);
        dual(1'b0, 1'b0, 2'd3, '0, 1'b1, 1'b0, 2'd3, '0, r0, r1);
        check("R9 core0 on lane0 wins", r0, 32'd1);
        check("R9 core1 on lane1 loses", r1, 32'd0);
        acc(1'b0, 1'b1, 2'd3, 32'd1, r);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        idle();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_lock();
        t_ring();
        t_clear();
        t_race();
        t_ignore();
        t_prio();
        summary();
    end

endmodule